// File: doc/BRIEF.md
# Burst Write Initiator Sequencer

This block is the initiating side of a registered parallel bus, built for burst writes. A local requester hands over one command: a start address, a command code, a byte count, and the requester's bus and device numbers. The block then requests the bus and waits for a grant. It drives an address phase and then an attribute phase. After that it waits a bounded time for a target to claim the cycle. Once the target claims it, the block streams write words from a local source. It never inserts a wait state of its own.

The burst ends in one of three ways. Normally, the frame line is released two clocks before the initiator-ready line. A target stop ends it at the current data phase. If no target claims the cycle in time, the burst ends with a master abort. In every case a single turnaround clock follows with all outputs released. In that clock the block pulses a completion strobe, together with the number of bytes moved and flags for abort, target stop and source underrun.

All bus lines use active-low levels. The output enables show when the block owns the control and address/data lines.

Top module: `burst_master_seq`

## Requirements
- R1: After reset `req_n`, `frame_n` and `irdy_n` are high, `ctl_oe`, `ad_oe` and `done` are low, and `cmd_ready` is high.
- R2: A command presented while `cmd_ready` is high is taken at that clock edge. `req_n` is low from the next clock and stays low until `gnt_n` is sampled low.
- R3: The clock after `gnt_n` is sampled low is the address phase: `frame_n` low, `ad_out` = address, `cbe_out` = command code.
- R4: The next clock is the attribute phase: `frame_n` low, `cbe_out` = 0, and `ad_out` = {bus[7:0] in bits 31:24, device[4:0] in bits 23:19, zero in bits 18:12, byte count in bits 11:0}.
- R5: After the attribute phase the block holds `frame_n` low and `irdy_n` high while it samples `devsel_n` for up to five clocks (four response clocks plus one margin clock).
- R6: If `devsel_n` is not sampled low in those five clocks, the block releases the bus and reports `done` with `abort_err` high and `xfer_bytes` = 0.
- R7: From the clock after `devsel_n` is sampled low, `irdy_n` stays low through the last data phase. Every clock with `trdy_n` low is a data phase in which `ad_out` = `wr_data`, `cbe_out` = 0 and `wr_take` is high.
- R8: The burst length in 32-bit words is the byte count divided by four. The two low bits are ignored, and a result below 2 words is raised to 2.
- R9: On a burst that is not stopped, `frame_n` is high during the last two data phases. `irdy_n` therefore rises two clocks after `frame_n`.
- R10: A data phase with `stop_n` low is the last one. `done` then reports `stop_seen` high and `xfer_bytes` = 4 × the number of phases completed, including that one.
- R11: `wr_valid` low during a data phase does not delay the burst. It sets `underrun_err` in the completion report.
- R12: The clock after the last data phase, or after the abort, is one turnaround clock with `ctl_oe`, `ad_oe` low, `irdy_n` high and `done` high. `cmd_ready` is high the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted at this edge |
| cmd_addr | input | DW | Burst start address |
| cmd_code | input | 4 | Bus command code |
| cmd_bytes | input | BCW | Byte count |
| cmd_bus | input | 8 | Requester bus number |
| cmd_dev | input | 5 | Requester device number |
| wr_data | input | DW | Write word from local source |
| wr_valid | input | 1 | Source word valid |
| wr_take | output | 1 | Word consumed this clock |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | Cycle frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| ctl_oe | output | 1 | Drive enable for frame/initiator-ready |
| ad_out | output | DW | Address/data bus value |
| cbe_out | output | 4 | Command / byte-enable value |
| ad_oe | output | 1 | Drive enable for address/data and command lines |
| devsel_n | input | 1 | Target claim, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |
| done | output | 1 | Completion strobe (turnaround clock) |
| abort_err | output | 1 | Master abort, valid with done |
| stop_seen | output | 1 | Ended by target stop, valid with done |
| underrun_err | output | 1 | Source underrun, valid with done |
| xfer_bytes | output | BCW | Bytes transferred, valid with done |

## Verification
Every bus output is decoded from the state register, so each phase shows up one clock after the input edge that causes it. The request comes one clock after acceptance. The address phase comes one clock after the grant is sampled, and the attribute phase follows it. The first data phase comes one clock after the target claim is sampled. The completion report appears one clock after the last data phase, or after the fifth unclaimed clock. The bench's target, arbiter and source drive their signals at the falling edge. The monitor samples one time unit later, inside the same clock. An expected item is therefore compared in the very clock the phase occupies. Each item is popped in phase order, so a phase that arrives one clock early or late pops the wrong item.

// File: rtl/burst_master_seq.sv
module burst_master_seq #(
  parameter int DW       = 32,
  parameter int BCW      = 12,
  parameter int DEV_WAIT = 4
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [DW-1:0]  cmd_addr,
  input  logic [3:0]     cmd_code,
  input  logic [BCW-1:0] cmd_bytes,
  input  logic [7:0]     cmd_bus,
  input  logic [4:0]     cmd_dev,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_valid,
  output logic           wr_take,
  output logic           req_n,
  input  logic           gnt_n,
  output logic           frame_n,
  output logic           irdy_n,
  output logic           ctl_oe,
  output logic [DW-1:0]  ad_out,
  output logic [3:0]     cbe_out,
  output logic           ad_oe,
  input  logic           devsel_n,
  input  logic           trdy_n,
  input  logic           stop_n,
  output logic           done,
  output logic           abort_err,
  output logic           stop_seen,
  output logic           underrun_err,
  output logic [BCW-1:0] xfer_bytes
);
  localparam int WW   = BCW - 2;
  localparam int TW   = $clog2(DEV_WAIT + 2);
  localparam int PADW = DW - 13 - BCW;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_ADDR, S_ATTR, S_WAIT, S_DATA, S_TURN
  } state_t;

  state_t         st;
  logic [DW-1:0]  addr_q;
  logic [3:0]     code_q;
  logic [BCW-1:0] bytes_q;
  logic [7:0]     bus_q;
  logic [4:0]     dev_q;
  logic [WW-1:0]  rem_q, cnt_q;
  logic [TW-1:0]  wt_q;
  logic           abort_q, stop_q, under_q;
  logic [WW-1:0]  words_in;
  logic [DW-1:0]  attr_word;
  logic           xfer, last;

  assign words_in  = (cmd_bytes[BCW-1:2] < WW'(2)) ? WW'(2) : cmd_bytes[BCW-1:2];
  assign attr_word = {bus_q, dev_q, {PADW{1'b0}}, bytes_q};
  assign xfer      = (st == S_DATA) && !trdy_n;
  assign last      = xfer && ((rem_q == WW'(1)) || !stop_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      code_q  <= '0;
      bytes_q <= '0;
      bus_q   <= '0;
      dev_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      wt_q    <= '0;
      abort_q <= 1'b0;
      stop_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          addr_q  <= cmd_addr;
          code_q  <= cmd_code;
          bytes_q <= cmd_bytes;
          bus_q   <= cmd_bus;
          dev_q   <= cmd_dev;
          rem_q   <= words_in;
          cnt_q   <= '0;
          abort_q <= 1'b0;
          stop_q  <= 1'b0;
          under_q <= 1'b0;
          st      <= S_REQ;
        end
        S_REQ:  if (!gnt_n) st <= S_ADDR;
        S_ADDR: st <= S_ATTR;
        S_ATTR: begin
          wt_q <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (!devsel_n) st <= S_DATA;
          else if (wt_q == TW'(DEV_WAIT)) begin
            abort_q <= 1'b1;
            st      <= S_TURN;
          end else wt_q <= wt_q + TW'(1);
        end
        S_DATA: if (xfer) begin
          rem_q <= rem_q - WW'(1);
          cnt_q <= cnt_q + WW'(1);
          if (!wr_valid) under_q <= 1'b1;
          if (!stop_n)   stop_q  <= 1'b1;
          if (last)      st      <= S_TURN;
        end
        S_TURN:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (st == S_IDLE);
  assign req_n        = (st != S_REQ);
  assign ctl_oe       = (st == S_ADDR) || (st == S_ATTR) || (st == S_WAIT) || (st == S_DATA);
  assign ad_oe        = ctl_oe;
  assign frame_n      = !((st == S_ADDR) || (st == S_ATTR) || (st == S_WAIT) ||
                          ((st == S_DATA) && (rem_q > WW'(2))));
  assign irdy_n       = (st != S_DATA);
  assign wr_take      = xfer;
  assign ad_out       = (st == S_ADDR) ? addr_q :
                        (st == S_ATTR) ? attr_word :
                        (st == S_DATA) ? wr_data : '0;
  assign cbe_out      = (st == S_ADDR) ? code_q : 4'h0;
  assign done         = (st == S_TURN);
  assign abort_err    = done && abort_q;
  assign stop_seen    = done && stop_q;
  assign underrun_err = done && under_q;
  assign xfer_bytes   = {cnt_q, 2'b00};
endmodule

// File: rtl/burst_master_seq_chk.sv
module burst_master_seq_chk #(
  parameter int BCW = 12
)(
  input logic           clk,
  input logic           rst_n,
  input logic           req_n,
  input logic           gnt_n,
  input logic           frame_n,
  input logic           irdy_n,
  input logic           stop_n,
  input logic [3:0]     cbe_out,
  input logic           done,
  input logic           abort_err,
  input logic [BCW-1:0] xfer_bytes,
  input logic           cmd_ready
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && gnt_n) |=> !req_n); // R2
  AST_ADDR_ON_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !gnt_n) |=> !frame_n); // R3
  AST_ATTR_NO_CBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |=> (!frame_n && cbe_out == 4'h0)); // R4
  AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && abort_err) |-> (xfer_bytes == '0)); // R6
  AST_IRDY_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !frame_n && stop_n) |=> !irdy_n); // R7
  AST_FRAME_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_n) && !irdy_n && stop_n) |=> !irdy_n); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready)); // R12
endmodule

bind burst_master_seq burst_master_seq_chk #(.BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .gnt_n(gnt_n),
  .frame_n(frame_n), .irdy_n(irdy_n), .stop_n(stop_n), .cbe_out(cbe_out),
  .done(done), .abort_err(abort_err), .xfer_bytes(xfer_bytes),
  .cmd_ready(cmd_ready)
);

// File: tb/burst_master_seq_tb.sv
module burst_master_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [3:0]  cmd_code = '0;
  logic [11:0] cmd_bytes = '0;
  logic [7:0]  cmd_bus = '0;
  logic [4:0]  cmd_dev = '0;
  logic [31:0] wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_take;
  logic        req_n, gnt_n = 1'b1;
  logic        frame_n, irdy_n, ctl_oe, ad_oe;
  logic [31:0] ad_out;
  logic [3:0]  cbe_out;
  logic        devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic        done, abort_err, stop_seen, underrun_err;
  logic [11:0] xfer_bytes;

  burst_master_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_code(cmd_code), .cmd_bytes(cmd_bytes),
    .cmd_bus(cmd_bus), .cmd_dev(cmd_dev), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_take(wr_take), .req_n(req_n), .gnt_n(gnt_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .ctl_oe(ctl_oe), .ad_out(ad_out), .cbe_out(cbe_out),
    .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .done(done), .abort_err(abort_err), .stop_seen(stop_seen),
    .underrun_err(underrun_err), .xfer_bytes(xfer_bytes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  logic [36:0] dq[$];
  logic [14:0] rq[$];
  string cur_tag = "";
  int t_lat = 1, t_gd = 0, t_stop = 0, t_under = 0;
  logic [15:0] t_seed = '0;
  int rc = 0, tc = 0, kk = 0;
  bit on_bus = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // target, arbiter, data source and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_n) rc++; else rc = 0;
      gnt_n = !(!req_n && rc > t_gd);
      if (ctl_oe) begin
        if (!on_bus) begin on_bus = 1; tc = 0; kk = 0; end
        else tc++;
        if (!irdy_n) kk++;
        devsel_n = !(t_lat != 0 && tc >= 1 + t_lat);
        trdy_n   = devsel_n;
        stop_n   = !(!irdy_n && kk == t_stop);
        wr_valid = !(!irdy_n && kk == t_under);
        wr_data  = {t_seed, kk[15:0]};
        #1;
        if (tc < 2 || !irdy_n) begin
          if (dq.size() == 0) check(0, "R3/R4/R7 unexpected phase", {27'd0, frame_n, cbe_out, ad_out}, 0);
          else begin
            logic [36:0] e;
            e = dq.pop_front();
            check({frame_n, cbe_out, ad_out} == e,
                  (tc == 0) ? "R3 address phase" : (tc == 1) ? "R4 attribute phase" : "R7/R9 data phase",
                  {27'd0, frame_n, cbe_out, ad_out}, {27'd0, e});
            if (!irdy_n) check(wr_take == 1'b1, "R7 wr_take", wr_take, 1);
          end
        end else begin
          check(irdy_n && !frame_n, "R5 claim wait", {frame_n, irdy_n}, 2'b01);
        end
      end else begin
        on_bus = 0; devsel_n = 1; trdy_n = 1; stop_n = 1; wr_valid = 0;
        #1;
      end
      if (done) begin
        check(!ctl_oe && !ad_oe && irdy_n, "R12 turnaround release", {ctl_oe, ad_oe, irdy_n}, 3'b001);
        check(dq.size() == 0, "R12 phases left over", dq.size(), 0);
        if (rq.size() == 0) check(0, {cur_tag, " unexpected done"}, 1, 0);
        else begin
          logic [14:0] r;
          r = rq.pop_front();
          check({abort_err, stop_seen, underrun_err, xfer_bytes} == r, cur_tag,
                {abort_err, stop_seen, underrun_err, xfer_bytes}, r);
        end
      end
    end
  end

  task automatic run(input logic [31:0] a, input logic [3:0] c, input int bytes,
                     input logic [7:0] b, input logic [4:0] d, input int lat, input int gd,
                     input int stp, input int und, input logic [15:0] seed, input string tag);
    int n, m;
    bit ab, sp, un;
    n = bytes >> 2;
    if (n < 2) n = 2;
    ab = (lat == 0 || lat > 5);
    m = ab ? 0 : ((stp != 0 && stp <= n) ? stp : n);
    sp = !ab && stp != 0 && stp <= n;
    un = !ab && und != 0 && und <= m;
    dq.push_back({1'b0, c, a});
    dq.push_back({1'b0, 4'h0, b, d, 7'd0, bytes[11:0]});
    for (int k = 1; k <= m; k++)
      dq.push_back({(n - k + 1) <= 2, 4'h0, seed, k[15:0]});
    rq.push_back({ab, sp, un, m[9:0], 2'b00});
    @(negedge clk);
    cur_tag = tag; t_lat = lat; t_gd = gd; t_stop = stp; t_under = und; t_seed = seed;
    cmd_addr = a; cmd_code = c; cmd_bytes = bytes[11:0]; cmd_bus = b; cmd_dev = d;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    #2;
    check(!req_n && !cmd_ready, "R2 request after accept", {req_n, cmd_ready}, 2'b00);
    while (rq.size() != 0) @(negedge clk);
    @(negedge clk);
    #2;
    check(cmd_ready, "R12 idle after turnaround", cmd_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(req_n && frame_n && irdy_n && !ctl_oe && !ad_oe && !done && cmd_ready,
          "R1 reset state", {req_n, frame_n, irdy_n, ctl_oe, ad_oe, done, cmd_ready}, 7'b1110001);
    @(negedge clk);
    rst_n = 1;
    run(32'h1000_0040, 4'h7, 16, 8'h03, 5'd2,  1, 0, 0, 0, 16'hA100, "R7 basic burst");
    run(32'h2000_0000, 4'hB, 32, 8'h11, 5'd9,  5, 3, 0, 0, 16'hB200, "R5 slowest claim");
    run(32'h3000_0100, 4'h7, 16, 8'h01, 5'd1,  0, 1, 0, 0, 16'hC300, "R6 no claim abort");
    run(32'h3000_0200, 4'h7, 16, 8'h01, 5'd1,  6, 0, 0, 0, 16'hC400, "R6 late claim abort");
    run(32'h4000_0000, 4'h7, 40, 8'h22, 5'd3,  2, 0, 3, 0, 16'hD500, "R10 target stop mid burst");
    run(32'h4000_1000, 4'h7, 16, 8'h22, 5'd3,  1, 2, 4, 0, 16'hD600, "R10 target stop last phase");
    run(32'h5000_0000, 4'h7, 12, 8'h05, 5'd7,  3, 0, 0, 2, 16'hE700, "R11 source underrun");
    run(32'h6000_0000, 4'h7,  6, 8'h06, 5'd4,  1, 0, 0, 0, 16'hF800, "R8 short count raised");
    run(32'h6000_0080, 4'h7, 14, 8'h06, 5'd4,  2, 1, 0, 0, 16'hF900, "R8 low bits ignored");
    run(32'h7000_0000, 4'h7,  8, 8'h07, 5'd8,  4, 0, 0, 0, 16'h1A00, "R9 two word burst");
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule